// File: doc/BRIEF.md
# Dual-Channel Interleaved Sample Output Formatter

This block merges two sample streams that are captured together on a shared conversion clock onto one narrow output bus. Channel A is presented on the rising phase of the conversion clock and channel B on the falling phase, with a channel flag that tracks the phase. The block is clocked by a fast clock at twice the conversion rate. An internal phase bit divides it down, so every register updates on a single edge and the half-cycle step between the two channels is one fast cycle.

Words pass through a fixed-depth alignment pipeline. Each word is recoded as it is loaded onto the bus, either left as offset binary or turned into two's complement. An active-low output enable models the three-state pins as a data bus plus an enable flag. A power-down input freezes the whole block, so the last bus word and flag level stay visible. After reset the bus stays at zero until the pipeline has filled.

Top module: `dual_lane_interleaver`

## Requirements
- R1: While reset is asserted and output enable is low, `dout` is 0, `dout_en` is 1 and `chan_a` is 0.
- R2: When `pd` is low, `chan_a` inverts on every fast clock edge. A fast edge at which `chan_a` goes from 0 to 1 is a conversion rising edge, and at that edge both `samp_a` and `samp_b` are captured.
- R3: A channel A word captured at conversion rising edge k is loaded onto the bus at conversion rising edge k+LAT (2*LAT fast cycles later, LAT=5 by default). It is visible while `chan_a` is 1.
- R4: The channel B word from the same capture is loaded one fast cycle after its channel A word, at the falling edge, and is visible while `chan_a` is 0.
- R5: With `fmt_twos` low at the load edge, the bus word equals the captured offset-binary sample: 0 is negative full scale, 0x3FF is positive full scale minus one LSB and 0x200 is zero.
- R6: With `fmt_twos` high at the load edge, the bus word is the captured sample with bit W-1 (the MSB) inverted. The coding is fixed when the word is loaded.
- R7: While `oe_n` is high, `dout_en` is 0 and `dout` reads all zeros in the same cycle. The held bus word comes back when `oe_n` returns low.
- R8: A fast edge with `pd` high changes no state: the bus word, `chan_a`, the pipeline and the capture order all hold, and they resume unchanged after `pd` falls.
- R9: After reset, the bus stays 0 through the first LAT conversion rising edges and their falling edges, until the first captured pair reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock at twice the conversion rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_a | input | W | Channel A sample, offset binary |
| samp_b | input | W | Channel B sample, offset binary |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| oe_n | input | 1 | Active-low output enable |
| pd | input | 1 | Power-down hold |
| dout | output | W | Multiplexed output word, zero while disabled |
| dout_en | output | 1 | Output drive enable, the three-state control |
| chan_a | output | 1 | 1 while channel A data is on the bus, 0 for channel B |

## Verification
Power-down and output disable can act in the same cycle. The bench raises `pd` and `oe_n` together, then lowers `oe_n` while `pd` is still high. The word then revealed must be exactly the one held before the freeze, and streaming must resume in the same A/B order once `pd` falls. A format change can also land on the same edge as a bus load. Because the bench changes `fmt_twos` freely while streaming, every A and B word is judged against the coding that was present at its own load edge.

// File: rtl/dual_lane_interleaver.sv
module dual_lane_interleaver #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] samp_a,
  input  logic [W-1:0] samp_b,
  input  logic         fmt_twos,
  input  logic         oe_n,
  input  logic         pd,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         chan_a
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [W-1:0] MSB = {1'b1, {(W-1){1'b0}}};

  logic         ph;
  logic [W-1:0] pa [LAT];
  logic [W-1:0] pb [LAT];
  logic [W-1:0] bhold, bus;
  logic [CW-1:0] fill;
  logic         live;

  wire          rise  = !ph && !pd;
  wire          fall  = ph && !pd;
  wire          full  = (fill == CW'(LAT));
  wire [W-1:0]  fmask = fmt_twos ? MSB : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   ph <= 1'b0;
    else if (!pd) ph <= ~ph;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pa[0] <= '0;
      pb[0] <= '0;
    end else if (rise) begin
      pa[0] <= samp_a;
      pb[0] <= samp_b;
    end

  for (genvar i = 1; i < LAT; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pa[i] <= '0;
        pb[i] <= '0;
      end else if (rise) begin
        pa[i] <= pa[i-1];
        pb[i] <= pb[i-1];
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              fill <= '0;
    else if (rise && !full)  fill <= fill + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus   <= '0;
      bhold <= '0;
      live  <= 1'b0;
    end else if (rise && full) begin
      bus   <= pa[LAT-1] ^ fmask;
      bhold <= pb[LAT-1];
      live  <= 1'b1;
    end else if (fall && live) begin
      bus   <= bhold ^ fmask;
    end

  assign dout    = oe_n ? '0 : bus;
  assign dout_en = !oe_n;
  assign chan_a  = ph;
endmodule

// File: rtl/dual_lane_interleaver_chk.sv
module dual_lane_interleaver_chk #(
  parameter int W   = 10,
  parameter int LAT = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         pd,
  input logic         oe_n,
  input logic [W-1:0] dout,
  input logic         dout_en,
  input logic         chan_a,
  input logic [W-1:0] bus
);
  localparam int RW = $clog2(LAT + 2);
  logic [RW-1:0] rcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rcnt <= '0;
    else if (!pd && !chan_a && rcnt != RW'(LAT + 1)) rcnt <= rcnt + 1'b1;

  AST_CHAN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pd |=> chan_a != $past(chan_a));                          // R2
  AST_PD_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(chan_a));                                   // R8
  AST_PD_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> $stable(bus));                                      // R8
  AST_OE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (dout == '0 && !dout_en));                        // R7
  AST_OE_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (dout == bus && dout_en));                       // R7
  AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rcnt <= RW'(LAT)) |-> bus == '0);                         // R9
endmodule

bind dual_lane_interleaver dual_lane_interleaver_chk #(.W(W), .LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .pd(pd), .oe_n(oe_n), .dout(dout),
  .dout_en(dout_en), .chan_a(chan_a), .bus(bus)
);

// File: tb/dual_lane_interleaver_tb_top.sv
module dual_lane_interleaver_tb_top;
  localparam int W   = 10;
  localparam int LAT = 5;

  typedef struct packed { logic [W-1:0] a; logic [W-1:0] b; } pair_t;

  logic clk = 0, rst_n = 0, fmt_twos = 0, oe_n = 0, pd = 0;
  logic [W-1:0] samp_a = '0, samp_b = '0;
  logic [W-1:0] dout;
  logic dout_en, chan_a;

  int total = 0, bad = 0;
  bit mon_on = 0;

  dual_lane_interleaver #(.W(W), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .pd(pd),
    .dout(dout), .dout_en(dout_en), .chan_a(chan_a)
  );

  always #10 clk = ~clk;

  logic [W-1:0] a_q, b_q;
  logic fmt_q, pd_q;
  always @(posedge clk) begin
    a_q <= samp_a; b_q <= samp_b; fmt_q <= fmt_twos; pd_q <= pd;
  end

  function automatic logic [W-1:0] code(logic [W-1:0] v, logic twos);
    return twos ? (v ^ {1'b1, {(W-1){1'b0}}}) : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  pair_t capq[$];
  logic [W-1:0] exp_bus = '0, pendb = '0;
  bit pendv = 0, prev_ch = 0;

  always @(negedge clk) if (mon_on) begin
    string tag;
    pair_t it;
    if (pd_q) begin
      chk(chan_a == prev_ch, "R8", chan_a, prev_ch);
      tag = "R8";
    end else begin
      chk(chan_a == !prev_ch, "R2", chan_a, !prev_ch);
      if (chan_a) begin
        if (capq.size() == LAT) begin
          it = capq.pop_front();
          exp_bus = code(it.a, fmt_q);
          pendb = it.b;
          pendv = 1;
        end
        capq.push_back('{a: a_q, b: b_q});
      end else if (pendv) begin
        exp_bus = code(pendb, fmt_q);
      end
      if (!pendv)      tag = "R9";
      else if (chan_a) tag = fmt_q ? "R3/R6" : "R3/R5";
      else             tag = fmt_q ? "R4/R6" : "R4/R5";
    end
    prev_ch = chan_a;
    if (oe_n) chk(dout == '0 && !dout_en, "R7", {dout_en, dout}, 0);
    else      chk(dout == exp_bus && dout_en, tag, {dout_en, dout}, {1'b1, exp_bus});
  end

  task automatic step(logic [W-1:0] a, logic [W-1:0] b);
    samp_a = a; samp_b = b;
    @(posedge clk); #5;
  endtask

  task automatic stream(int n);
    for (int i = 0; i < n; i++) step(W'($urandom), W'($urandom));
  endtask

  initial begin
    #(20 * 20000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(dout == '0 && dout_en && !chan_a, "R1", {chan_a, dout_en, dout}, {2'b01, {W{1'b0}}});
    @(posedge clk); #5 rst_n = 1;
    @(posedge clk); mon_on = 1; #5;
    // R9 fill, then R3 R4 R5 offset binary streaming
    stream(30);
    // R6 two's complement, with coding changes landing on load edges
    fmt_twos = 1; stream(16);
    fmt_twos = 0; step(10'h155, 10'h2AA);
    fmt_twos = 1; stream(7);
    // R7 output disable and recovery
    oe_n = 1; stream(6);
    oe_n = 0; stream(4);
    // R8 power-down hold
    pd = 1; stream(7);
    pd = 0; stream(6);
    // R7 with R8 in the same cycle
    pd = 1; oe_n = 1; stream(3);
    oe_n = 0; stream(3);
    pd = 0; stream(5);
    // R5 R6 boundary codes
    fmt_twos = 0;
    step(10'h000, 10'h3FF); step(10'h000, 10'h3FF);
    step(10'h200, 10'h1FF); step(10'h200, 10'h1FF);
    fmt_twos = 1;
    step(10'h000, 10'h3FF); step(10'h000, 10'h3FF);
    step(10'h200, 10'h1FF); step(10'h200, 10'h1FF);
    stream(2 * LAT + 4);
    fmt_twos = 0; stream(2 * LAT + 4);
    mon_on = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule